// File: doc/BRIEF.md
# Sub-vector Transposing Index Generator

This block walks a vector loop whose elements are short sub-vectors of one to four lanes. It emits one pair of register offsets per accepted step: a source offset and a destination offset, both relative to their base registers. The total number of steps in a loop is the vector length times the sub-vector length. The pair can drive a move engine that copies element `srcOff` of a source group into element `dstOff` of a destination group.

Each side has its own nesting of the two loops. By default the vector loop is outer and the lane loop is inner, so offsets simply count up. When the source transpose enable is set, the source side nests the lane loop outside the vector loop. The source then gathers lane 0 of every sub-vector first, then lane 1, and so on. The destination transpose enable does the same for the destination side. The two sides always advance together, and setting both enables is legal and fully deterministic. The offset of vector index i and lane j is always i*SUBVL+j. Only the order of visiting changes.

A run is started with a one-cycle `start` strobe. The configuration is captured at that moment. Pairs are handed out under a valid/ready handshake, and the final pair carries a last flag. A new start may coincide with the acceptance of the final pair, so consecutive loops run with no idle cycle between them.

Top module: `subvecIndexGen`

## Requirements
- R1: After reset, `outValid` and `outLast` are 0.
- R2: A `start` taken while idle with `cfgVl` nonzero makes `outValid` 1 on the next cycle, with both offsets 0. A `start` with `cfgVl` equal to 0 is ignored, and `outValid` stays 0.
- R3: The sub-vector length is `cfgSubvlCode`+1, so codes 0, 1, 2 and 3 select lengths 1, 2, 3 and 4.
- R4: With `cfgPack` 0, the source offset at step k (counting from 0) is k.
- R5: With `cfgPack` 1, the source offset at step k is (k mod VL)*SUBVL + (k div VL).
- R6: `cfgUnpack` selects the destination order by the same rule: step k gives offset k when the enable is 0, and (k mod VL)*SUBVL + (k div VL) when it is 1.
- R7: Setting both enables applies the transposed order to both sides at once, and the two sides stay in step.
- R8: A step advances only when `outValid` and `outReady` are both 1. While `outReady` is 0, the offsets and flags hold.
- R9: A run presents exactly VL*SUBVL pairs. `outLast` is 1 on the final pair only. After the final pair is accepted with no new start, `outValid` is 0 on the next cycle.
- R10: A `start`, and any change of the configuration inputs, during a run that is not at its final accepted step, has no effect on the run in progress.
- R11: A `start` in the same cycle that the final pair is accepted begins the new run on the next cycle, with offsets 0 and the new configuration.
- R12: A `cfgVl` above `MAXVL` is treated as `MAXVL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle strobe that begins a run |
| cfgVl | input | VL_W | Vector length, captured at start |
| cfgSubvlCode | input | 2 | Sub-vector length minus one, captured at start |
| cfgPack | input | 1 | Transposed order on the source side |
| cfgUnpack | input | 1 | Transposed order on the destination side |
| outReady | input | 1 | Consumer accepts the current pair |
| outValid | output | 1 | A pair is presented |
| srcOff | output | OFF_W | Source element offset |
| dstOff | output | OFF_W | Destination element offset |
| outLast | output | 1 | Current pair is the final one of the run |

## Verification
The two functions that can fall in the same cycle are the completion of a run and the start of the next one. This happens when the final pair is accepted while `start` is high. The bench provokes it with directed chained runs that change the vector length, the sub-vector length and both order enables at the hand-over. It then judges that the very next cycle shows a valid pair at offsets 0 that follows the new configuration, with no idle gap. A second overlap is a `start` that arrives mid-run together with scrambled configuration inputs. The bench checks at the ports that the offsets already in flight continue unchanged.

// File: rtl/subvecIndexPkg.sv
package subvecIndexPkg;

  typedef struct packed {
    logic load;
    logic adv;
  } stepCtl_t;

endpackage

// File: rtl/subvecIndexCtrl.sv
module subvecIndexCtrl
  import subvecIndexPkg::*;
#(
  parameter int MAXVL = 64,
  localparam int VL_W = $clog2(MAXVL + 1),
  localparam int CNT_W = $clog2(MAXVL * 4)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            ready,
  input  logic [VL_W-1:0] vlEff,
  input  logic [2:0]      svLen,
  output stepCtl_t        ctl,
  output logic            busy,
  output logic            isLast
);

  logic [CNT_W-1:0] stepCnt;
  logic [CNT_W-1:0] lastIdx;
  logic [CNT_W:0]   totalSteps;
  logic             accept;

  assign totalSteps = (CNT_W+1)'(vlEff) * (CNT_W+1)'(svLen);
  assign isLast     = busy && (stepCnt == lastIdx);
  assign accept     = busy && ready;

  always_comb begin
    ctl.load = start && (vlEff != '0) && (!busy || (accept && isLast));
    ctl.adv  = accept && !isLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      stepCnt <= '0;
      lastIdx <= '0;
    end else if (ctl.load) begin
      busy    <= 1'b1;
      stepCnt <= '0;
      lastIdx <= CNT_W'(totalSteps - 1'b1);
    end else if (accept && isLast) begin
      busy <= 1'b0;
    end else if (ctl.adv) begin
      stepCnt <= stepCnt + 1'b1;
    end
  end

endmodule

// File: rtl/subvecIndexWalker.sv
module subvecIndexWalker
  import subvecIndexPkg::*;
#(
  parameter int MAXVL = 64,
  localparam int VL_W = $clog2(MAXVL + 1),
  localparam int OFF_W = $clog2(MAXVL * 4)
) (
  input  logic             clk,
  input  logic             rstN,
  input  stepCtl_t         ctl,
  input  logic             swapIn,
  input  logic [VL_W-1:0]  vlIn,
  input  logic [2:0]       svIn,
  output logic [OFF_W-1:0] off
);

  logic [VL_W-1:0] vIdx;
  logic [1:0]      sIdx;
  logic [VL_W-1:0] vlR;
  logic [2:0]      svR;
  logic            swapR;
  logic            vWrap;
  logic            sWrap;

  assign vWrap = (vIdx == vlR - 1'b1);
  assign sWrap = ({1'b0, sIdx} == svR - 1'b1);
  assign off   = OFF_W'(OFF_W'(vIdx) * OFF_W'(svR) + OFF_W'(sIdx));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vIdx  <= '0;
      sIdx  <= '0;
      vlR   <= VL_W'(1);
      svR   <= 3'd1;
      swapR <= 1'b0;
    end else if (ctl.load) begin
      vIdx  <= '0;
      sIdx  <= '0;
      vlR   <= vlIn;
      svR   <= svIn;
      swapR <= swapIn;
    end else if (ctl.adv) begin
      if (swapR) begin
        if (vWrap) begin
          vIdx <= '0;
          sIdx <= sIdx + 1'b1;
        end else begin
          vIdx <= vIdx + 1'b1;
        end
      end else begin
        if (sWrap) begin
          sIdx <= '0;
          vIdx <= vIdx + 1'b1;
        end else begin
          sIdx <= sIdx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/subvecIndexPath.sv
module subvecIndexPath
  import subvecIndexPkg::*;
#(
  parameter int MAXVL = 64,
  localparam int VL_W = $clog2(MAXVL + 1),
  localparam int OFF_W = $clog2(MAXVL * 4)
) (
  input  logic             clk,
  input  logic             rstN,
  input  stepCtl_t         ctl,
  input  logic [VL_W-1:0]  vlEff,
  input  logic [2:0]       svLen,
  input  logic             cfgPack,
  input  logic             cfgUnpack,
  output logic [OFF_W-1:0] srcOff,
  output logic [OFF_W-1:0] dstOff
);

  logic [OFF_W-1:0] sideOff [2];

  for (genvar side = 0; side < 2; side++) begin : gSide
    subvecIndexWalker #(.MAXVL(MAXVL)) uWalk (
      .clk    (clk),
      .rstN   (rstN),
      .ctl    (ctl),
      .swapIn ((side == 0) ? cfgPack : cfgUnpack),
      .vlIn   (vlEff),
      .svIn   (svLen),
      .off    (sideOff[side])
    );
  end

  assign srcOff = sideOff[0];
  assign dstOff = sideOff[1];

endmodule

// File: rtl/subvecIndexGen.sv
module subvecIndexGen
  import subvecIndexPkg::*;
#(
  parameter int MAXVL = 64,
  localparam int VL_W = $clog2(MAXVL + 1),
  localparam int OFF_W = $clog2(MAXVL * 4)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [VL_W-1:0]  cfgVl,
  input  logic [1:0]       cfgSubvlCode,
  input  logic             cfgPack,
  input  logic             cfgUnpack,
  input  logic             outReady,
  output logic             outValid,
  output logic [OFF_W-1:0] srcOff,
  output logic [OFF_W-1:0] dstOff,
  output logic             outLast
);

  stepCtl_t        ctl;
  logic [VL_W-1:0] vlEff;
  logic [2:0]      svLen;

  assign vlEff = (cfgVl > VL_W'(MAXVL)) ? VL_W'(MAXVL) : cfgVl;
  assign svLen = {1'b0, cfgSubvlCode} + 3'd1;

  subvecIndexCtrl #(.MAXVL(MAXVL)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .ready  (outReady),
    .vlEff  (vlEff),
    .svLen  (svLen),
    .ctl    (ctl),
    .busy   (outValid),
    .isLast (outLast)
  );

  subvecIndexPath #(.MAXVL(MAXVL)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .vlEff     (vlEff),
    .svLen     (svLen),
    .cfgPack   (cfgPack),
    .cfgUnpack (cfgUnpack),
    .srcOff    (srcOff),
    .dstOff    (dstOff)
  );

endmodule

// File: rtl/subvecIndexGenChk.sv
module subvecIndexGenChk #(
  parameter int MAXVL = 64,
  localparam int VL_W = $clog2(MAXVL + 1),
  localparam int OFF_W = $clog2(MAXVL * 4)
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [VL_W-1:0]  cfgVl,
  input logic [1:0]       cfgSubvlCode,
  input logic             cfgPack,
  input logic             cfgUnpack,
  input logic             outReady,
  input logic             outValid,
  input logic [OFF_W-1:0] srcOff,
  input logic [OFF_W-1:0] dstOff,
  input logic             outLast
);

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid); // R9

  AST_IDLE_START: assert property (@(posedge clk) disable iff (!rstN)
    (!outValid && start && cfgVl != '0) |=> (outValid && srcOff == '0 && dstOff == '0)); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(srcOff) && $stable(dstOff) && $stable(outLast))); // R8

  AST_NO_EARLY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !outLast) |=> outValid); // R10

  AST_END_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast && !start) |=> !outValid); // R9

  AST_CHAIN_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast && start && cfgVl != '0) |=> (outValid && srcOff == '0 && dstOff == '0)); // R11

endmodule

bind subvecIndexGen subvecIndexGenChk #(.MAXVL(MAXVL)) uChk (.*);

// File: tb/subvecIndexGen_test.sv
module subvecIndexGen_test;

  localparam int MAXVL = 64;
  localparam int VL_W = $clog2(MAXVL + 1);
  localparam int OFF_W = $clog2(MAXVL * 4);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [VL_W-1:0]  cfgVl = '0;
  logic [1:0]       cfgSubvlCode = '0;
  logic             cfgPack = 1'b0;
  logic             cfgUnpack = 1'b0;
  logic             outReady = 1'b0;
  logic             outValid;
  logic [OFF_W-1:0] srcOff;
  logic [OFF_W-1:0] dstOff;
  logic             outLast;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  subvecIndexGen #(.MAXVL(MAXVL)) uut (
    .clk(clk), .rstN(rstN), .start(start), .cfgVl(cfgVl),
    .cfgSubvlCode(cfgSubvlCode), .cfgPack(cfgPack), .cfgUnpack(cfgUnpack),
    .outReady(outReady), .outValid(outValid), .srcOff(srcOff),
    .dstOff(dstOff), .outLast(outLast)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int expOff(input int k, input int vEff, input int sv, input bit sw);
    return sw ? (k % vEff) * sv + k / vEff : k;
  endfunction

  task automatic runBody(input int vl, input int code, input bit pk, input bit up,
                         input bit chain, input int nvl, input int ncode,
                         input bit npk, input bit nup, input bit noStall);
    int vEff = (vl > MAXVL) ? MAXVL : vl;
    int sv = code + 1;
    int total = vEff * sv;
    int k = 0;
    string pre = (vl > MAXVL) ? "R12 " : "";
    string both = (pk && up) ? "R7 " : "";
    while (k < total) begin
      bit isL = (k == total - 1);
      bit rdy;
      check(outValid === 1'b1, {pre, "R9 valid during run"}, int'(outValid), 1);
      check(int'(srcOff) == expOff(k, vEff, sv, pk),
            {pre, both, pk ? "R5 transposed src" : "R4 plain src"}, int'(srcOff), expOff(k, vEff, sv, pk));
      check(int'(dstOff) == expOff(k, vEff, sv, up),
            {pre, both, "R6 dst order"}, int'(dstOff), expOff(k, vEff, sv, up));
      check(outLast === isL, {pre, "R9 last flag, length per R3 code"}, int'(outLast), int'(isL));
      rdy = noStall || ($urandom % 4 != 0);
      if (isL && chain) begin
        rdy = 1'b1;
        start = 1'b1;
        cfgVl = VL_W'(nvl);
        cfgSubvlCode = 2'(ncode);
        cfgPack = npk;
        cfgUnpack = nup;
      end else if (!isL && ($urandom % 6 == 0)) begin
        start = 1'b1;
        cfgVl = VL_W'($urandom % 30 + 1);
        cfgSubvlCode = 2'($urandom % 4);
        cfgPack = ~cfgPack;
        cfgUnpack = ~cfgUnpack;
      end else begin
        start = 1'b0;
      end
      outReady = rdy;
      @(negedge clk);
      start = 1'b0;
      if (!rdy) begin
        check(outValid === 1'b1 && int'(srcOff) == expOff(k, vEff, sv, pk),
              "R8 stall hold", int'(srcOff), expOff(k, vEff, sv, pk));
      end
      if (rdy) k++;
    end
    outReady = 1'b0;
    if (chain) begin
      check(outValid === 1'b1 && srcOff == '0 && dstOff == '0,
            "R11 back-to-back restart", int'(outValid), 1);
    end else begin
      check(outValid === 1'b0, "R9 drop after final", int'(outValid), 0);
    end
  endtask

  task automatic startRun(input int vl, input int code, input bit pk, input bit up);
    cfgVl = VL_W'(vl);
    cfgSubvlCode = 2'(code);
    cfgPack = pk;
    cfgUnpack = up;
    start = 1'b1;
    outReady = 1'b0;
    @(negedge clk);
    start = 1'b0;
    cfgVl = VL_W'($urandom % 50);
    cfgSubvlCode = 2'($urandom % 4);
    cfgPack = ~pk;
    cfgUnpack = ~up;
    check(outValid === 1'b1 && srcOff == '0 && dstOff == '0, "R2 first pair at zero",
          int'(outValid), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check(outValid === 1'b0, "R1 reset valid", int'(outValid), 0);
    check(outLast === 1'b0, "R1 reset last", int'(outLast), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid === 1'b0, "R1 idle after reset", int'(outValid), 0);

    cfgVl = '0; cfgSubvlCode = 2'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(outValid === 1'b0, "R2 zero length ignored", int'(outValid), 0);

    // Directed: VL=2, length 3 via R3 code 2, source transposed: 0,3,1,4,2,5
    startRun(2, 2, 1'b1, 1'b0);
    runBody(2, 2, 1'b1, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0, 1'b1);
    startRun(3, 3, 1'b0, 1'b1);
    runBody(3, 3, 1'b0, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0, 1'b0);
    startRun(4, 1, 1'b1, 1'b1);
    runBody(4, 1, 1'b1, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0, 1'b0);
    startRun(1, 3, 1'b1, 1'b1);
    runBody(1, 3, 1'b1, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0, 1'b1);
    startRun(5, 0, 1'b1, 1'b0);
    runBody(5, 0, 1'b1, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0, 1'b0);
    startRun(100, 1, 1'b1, 1'b0);
    runBody(100, 1, 1'b1, 1'b0, 1'b0, 0, 0, 1'b0, 1'b0, 1'b1);

    // Chained hand-over: R11
    startRun(3, 2, 1'b0, 1'b0);
    runBody(3, 2, 1'b0, 1'b0, 1'b1, 2, 3, 1'b1, 1'b1, 1'b0);
    runBody(2, 3, 1'b1, 1'b1, 1'b1, 5, 1, 1'b0, 1'b1, 1'b0);
    runBody(5, 1, 1'b0, 1'b1, 1'b0, 0, 0, 1'b0, 1'b0, 1'b0);

    for (int r = 0; r < 40; r++) begin
      int vl = $urandom % 12 + 1;
      int code = $urandom % 4;
      bit pk = 1'($urandom % 2);
      bit up = 1'($urandom % 2);
      startRun(vl, code, pk, up);
      runBody(vl, code, pk, up, 1'b0, 0, 0, 1'b0, 1'b0, 1'b0);
      repeat ($urandom % 3) @(negedge clk);
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule